// File: doc/BRIEF.md
# Limit Fault Interrupt Controller

This block gathers limit-compare results for four voltage rails and three temperature sensors and turns them into a single active-low system-management interrupt. On every cycle where the sample strobe is high, it reads the comparator outputs for that conversion. For a voltage channel these are "above high limit" and "below low limit". For a temperature channel they are "above high limit" and "below hysteresis limit". The analog front end, the comparators and any fan logic sit outside this block.

Voltage faults are filtered. A channel must stay out of range for 1, 2, 4 or 8 consecutive samples, as chosen by a two-bit setting, before its status bit is set. Temperature faults are latched on the sample where either compare result goes from 0 to 1. Status bits are sticky and are cleared by writing a 1. Each status bit has an enable bit. The interrupt line is low while any enabled status bit is set. Software reaches the enable, status and live exceed flags through a byte-wide address/data port.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset the status and enable bits are all 0, the live exceed flags are 0 and `smi_no` is 1.
- R2: Register 0x31 bits 3:0 hold a live exceed flag per voltage channel. On each sample the flag is loaded with (high-compare OR low-compare). Bits 7:4 read 0.
- R3: A voltage status bit is set one cycle after the sample that completes the required run of consecutive out-of-range samples on that channel.
- R4: An in-range sample on a voltage channel resets its run count. After a channel sets its status, it cannot set it again until it has had an in-range sample.
- R5: `qsel_i` codes 0, 1, 2 and 3 require runs of 1, 2, 4 and 8 samples. Cycles without the sample strobe neither count nor break the run.
- R6: A temperature status bit is set after a sample on which its high-compare or its hysteresis-compare is 1 and was 0 at that channel's previous sample. A condition that stays asserted does not set the bit again.
- R7: Writing register 0x34 clears each status bit whose write-data bit is 1. Status bits written with 0 keep their value. Without such a write, status bits never fall.
- R8: If a set event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R9: The enable register (0x33) is read/write and the status register (0x34) is read/write-1-clear. In both, bit 0 is VCC, bits 3:1 are voltages 1 to 3, and bits 6:4 are temperatures 0 to 2.
- R10: Bit 7 of the enable register reads 1. Bit 7 of the status register reads 0. Writes do not change either bit.
- R11: `smi_no` is 0 exactly when some status bit and its matching enable bit are both 1. It follows changes to the registers in the same cycle.
- R12: Reads from any address other than 0x31, 0x33 and 0x34 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | High for one cycle per conversion result |
| volt_hi_i | input | 4 | Voltage above high limit, per channel |
| volt_lo_i | input | 4 | Voltage below low limit, per channel |
| temp_hi_i | input | 3 | Temperature above high limit, per channel |
| temp_hyst_i | input | 3 | Temperature below hysteresis limit, per channel |
| qsel_i | input | 2 | Consecutive-sample run length select (1, 2, 4, 8) |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| smi_no | output | 1 | System-management interrupt, active low |

## Verification
The bench breaks voltage runs with an in-range sample just before they complete. A design that forgets to reset its count would then fault one sample early. The bench also holds a channel out of range after clearing its status; a design without the one-shot guard would set the bit again on every sample. It lands a hardware set and a write-1 clear on the same bit in the same cycle, where a design with the wrong priority drops the fault. It writes zeros and reserved bits, so a design that clears on 0 or stores bit 7 shows a wrong read value. A behavioural model then runs random strobes, compare patterns, run-length changes and register traffic, and compares read data and the interrupt line on every cycle.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  localparam int NV = 4;
  localparam int NT = 3;
  localparam int NS = NV + NT;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int QW = 2;
  localparam int QMAX = (1 << QW) - 1;
  localparam int CW = QMAX + 2;
  localparam logic [AW-1:0] ADDR_EXC = 8'h31;
  localparam logic [AW-1:0] ADDR_EN  = 8'h33;
  localparam logic [AW-1:0] ADDR_STS = 8'h34;
endpackage

// File: rtl/volt_qual.sv
module volt_qual #(
  parameter int QW = 2,
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic          out_i,
  input  logic [QW-1:0] qsel_i,
  output logic          set_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] need;
  logic          fired_q;

  assign need  = CW'(1) << qsel_i;
  assign set_o = sample_i & out_i & ~fired_q & ((cnt_q + 1'b1) >= need);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (sample_i) begin
      if (!out_i) begin
        cnt_q   <= '0;
        fired_q <= 1'b0;
      end else if (!fired_q) begin
        if (set_o) begin
          cnt_q   <= '0;
          fired_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_ONE_PER_EXCURSION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |=> !set_o) else $error("second set inside one excursion"); // R4

  AST_IN_RANGE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !out_i) |=> !(sample_i && out_i && qsel_i != '0 && set_o))
    else $error("set right after in-range sample with run > 1"); // R4
endmodule

// File: rtl/temp_edge.sv
module temp_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic hi_i,
  input  logic hyst_i,
  output logic set_o
);
  logic hi_q, hyst_q;

  assign set_o = sample_i & ((hi_i & ~hi_q) | (hyst_i & ~hyst_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= 1'b0;
      hyst_q <= 1'b0;
    end else if (sample_i) begin
      hi_q   <= hi_i;
      hyst_q <= hyst_i;
    end
  end

  AST_HELD_HI_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && hi_i && !hyst_i) |=> !(sample_i && hi_i && !hyst_i && set_o))
    else $error("held high condition set again"); // R6
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import fault_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] set_i,
  input  logic [NV-1:0] exc_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [NS-1:0] en_o,
  output logic [NS-1:0] sts_o
);
  logic [NS-1:0] en_q, sts_q, clr;
  logic          wr_sts, wr_en;
  logic          unused_wbits;

  assign wr_sts       = wr_i && (addr_i == ADDR_STS);
  assign wr_en        = wr_i && (addr_i == ADDR_EN);
  assign clr          = wr_sts ? wdata_i[NS-1:0] : '0;
  assign unused_wbits = ^wdata_i[DW-1:NS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (wr_en) en_q <= wdata_i[NS-1:0];
      sts_q <= (sts_q & ~clr) | set_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_EXC: rdata_o[NV-1:0] = exc_i;
      ADDR_EN: begin
        rdata_o[NS-1:0] = en_q;
        rdata_o[DW-1]   = 1'b1;
      end
      ADDR_STS: rdata_o[NS-1:0] = sts_q;
      default: rdata_o = '0;
    endcase
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((sts_q & $past(set_i)) == $past(set_i)))
    else $error("set event lost"); // R8

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sts |=> ((sts_q & $past(wdata_i[NS-1:0] & ~set_i)) == '0))
    else $error("write-1 did not clear"); // R7

  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sts |=> ((sts_q & $past(sts_q & ~wdata_i[NS-1:0])) == $past(sts_q & ~wdata_i[NS-1:0])))
    else $error("write-0 changed status"); // R7

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_sts |=> ((sts_q & $past(sts_q)) == $past(sts_q)))
    else $error("status fell without clear"); // R7
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic [NV-1:0] volt_hi_i,
  input  logic [NV-1:0] volt_lo_i,
  input  logic [NT-1:0] temp_hi_i,
  input  logic [NT-1:0] temp_hyst_i,
  input  logic [QW-1:0] qsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          smi_no
);
  logic [NS-1:0] set_vec, en, sts;
  logic [NV-1:0] exc_q;

  for (genvar v = 0; v < NV; v++) begin : g_volt
    volt_qual #(.QW(QW), .CW(CW)) u_qual (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (sample_i),
      .out_i    (volt_hi_i[v] | volt_lo_i[v]),
      .qsel_i   (qsel_i),
      .set_o    (set_vec[v])
    );
  end

  for (genvar t = 0; t < NT; t++) begin : g_temp
    temp_edge u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sample_i (sample_i),
      .hi_i     (temp_hi_i[t]),
      .hyst_i   (temp_hyst_i[t]),
      .set_o    (set_vec[NV+t])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       exc_q <= '0;
    else if (sample_i) exc_q <= volt_hi_i | volt_lo_i;
  end

  fault_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .exc_i   (exc_q),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .en_o    (en),
    .sts_o   (sts)
  );

  assign smi_no = ~|(sts & en);

  AST_EXC_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> (exc_q == $past(volt_hi_i | volt_lo_i)))
    else $error("exceed flag not loaded"); // R2

  AST_SMI_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_EN && wdata_i[NS-1:0] == '0) |=> smi_no)
    else $error("interrupt low with all enables off"); // R11
endmodule

// File: tb/sim_fault_irq_ctrl.sv
module sim_fault_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sample = 1'b0, wr = 1'b0;
  logic [3:0] vhi = '0, vlo = '0;
  logic [2:0] thi = '0, thy = '0;
  logic [1:0] qsel = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       smi_n;

  int errors = 0, checks = 0;
  bit done = 0;

  int m_cnt[4];
  bit m_fired[4];
  bit m_phi[3], m_phy[3];
  bit [6:0] m_sts, m_en;
  bit [3:0] m_exc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .volt_hi_i(vhi), .volt_lo_i(vlo), .temp_hi_i(thi), .temp_hyst_i(thy),
    .qsel_i(qsel), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .smi_no(smi_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic bit [7:0] m_read(input bit [7:0] a);
    case (a)
      8'h31:   return {4'h0, m_exc};
      8'h33:   return {1'b1, m_en};
      8'h34:   return {1'b0, m_sts};
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_fired[i] = 0; end
    for (int i = 0; i < 3; i++) begin m_phi[i] = 0; m_phy[i] = 0; end
    m_sts = '0; m_en = '0; m_exc = '0;
  endtask

  task automatic m_step();
    bit [6:0] setv = '0;
    bit [6:0] clrv = '0;
    if (sample) begin
      for (int v = 0; v < 4; v++) begin
        if (!(vhi[v] || vlo[v])) begin m_cnt[v] = 0; m_fired[v] = 0; end
        else if (!m_fired[v]) begin
          if (m_cnt[v] + 1 >= (1 << qsel)) begin setv[v] = 1; m_fired[v] = 1; m_cnt[v] = 0; end
          else m_cnt[v]++;
        end
      end
      for (int t = 0; t < 3; t++) begin
        if ((thi[t] && !m_phi[t]) || (thy[t] && !m_phy[t])) setv[4+t] = 1;
        m_phi[t] = thi[t]; m_phy[t] = thy[t];
      end
      m_exc = vhi | vlo;
    end
    if (wr && addr == 8'h34) clrv = wdata[6:0];
    if (wr && addr == 8'h33) m_en = wdata[6:0];
    m_sts = (m_sts & ~clrv) | setv;
  endtask

  // compare, advance one clock, update model, drop strobes
  task automatic tick();
    #1;
    chk("R9 read vs model", rdata, m_read(addr));
    chk("R11 smi vs model", {7'h0, smi_n}, {7'h0, ~|(m_sts & m_en)});
    @(posedge clk);
    m_step();
    @(negedge clk);
    wr = 0; sample = 0;
  endtask

  task automatic rd(input bit [7:0] a, input bit [7:0] exp, input string tag);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wreg(input bit [7:0] a, input bit [7:0] d);
    addr = a; wdata = d; wr = 1; tick();
  endtask

  task automatic samp(input int n);
    for (int i = 0; i < n; i++) begin sample = 1; tick(); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 smi idle", {7'h0, smi_n}, 8'h01);
    rd(8'h34, 8'h00, "R1 status zero");
    rd(8'h33, 8'h80, "R1 R10 enable zero, bit7 one");
    rd(8'h31, 8'h00, "R1 exceed zero");

    wreg(8'h33, 8'hFF);
    rd(8'h33, 8'hFF, "R9 R10 enable write");
    wreg(8'h34, 8'hFF);
    rd(8'h34, 8'h00, "R10 status bit7 reads 0");

    // R3 run of 1
    qsel = 2'd0; vhi = 4'b0001; samp(1);
    rd(8'h34, 8'h01, "R3 VCC set after one sample");
    chk("R11 smi low", {7'h0, smi_n}, 8'h00);
    rd(8'h31, 8'h01, "R2 exceed VCC");
    wreg(8'h34, 8'h01);
    samp(2);
    rd(8'h34, 8'h00, "R4 no re-set while held out");
    vhi = 4'b0000; samp(1);
    rd(8'h31, 8'h00, "R2 exceed cleared in range");

    // R5 run of 2, broken by in-range
    qsel = 2'd1; vlo = 4'b0010; samp(1);
    rd(8'h34, 8'h00, "R5 run2 after one sample");
    vlo = 4'b0000; samp(1);
    vlo = 4'b0010; samp(1);
    rd(8'h34, 8'h00, "R4 count reset by in-range");
    tick(); tick();
    rd(8'h34, 8'h00, "R5 no strobe no count");
    samp(1);
    rd(8'h34, 8'h02, "R5 run2 complete");
    vlo = 4'b0000; samp(1);

    // R5 run of 8
    qsel = 2'd3; vhi = 4'b0100; samp(7);
    rd(8'h34, 8'h02, "R5 run8 after seven");
    samp(1);
    rd(8'h34, 8'h06, "R5 run8 complete");
    // R5 run of 4
    qsel = 2'd2; vhi = 4'b1000; samp(3);
    rd(8'h34, 8'h06, "R5 run4 after three");
    samp(1);
    rd(8'h34, 8'h0E, "R3 run4 complete");
    vhi = 4'b0000; samp(1);

    // R7 write zero keeps, write one clears
    wreg(8'h34, 8'hF1);
    rd(8'h34, 8'h0E, "R7 zeros keep status");
    wreg(8'h34, 8'h0A);
    rd(8'h34, 8'h04, "R7 ones clear");
    wreg(8'h34, 8'h04);

    // R6 temperature edges
    thi = 3'b001; samp(1);
    rd(8'h34, 8'h10, "R6 temp0 high edge");
    wreg(8'h34, 8'h10);
    samp(2);
    rd(8'h34, 8'h00, "R6 held high no re-set");
    thi = 3'b000; thy = 3'b001; samp(1);
    rd(8'h34, 8'h10, "R6 temp0 hysteresis edge");

    // R8 set beats clear
    addr = 8'h34; wdata = 8'h30; wr = 1; sample = 1; thi = 3'b010; tick();
    rd(8'h34, 8'h20, "R8 set wins over clear");

    // R11 enable gating
    wreg(8'h33, 8'h00);
    chk("R11 smi high with enables off", {7'h0, smi_n}, 8'h01);
    wreg(8'h33, 8'h20);
    chk("R11 smi low with enable on", {7'h0, smi_n}, 8'h00);

    // R12 unmapped
    rd(8'h00, 8'h00, "R12 unmapped 00");
    rd(8'h35, 8'h00, "R12 unmapped 35");

    // random traffic vs model
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] alist[4];
      alist[0] = 8'h31; alist[1] = 8'h33; alist[2] = 8'h34; alist[3] = 8'h10;
      sample = ($urandom % 3) != 0;
      vhi = 4'($urandom) & 4'($urandom);
      vlo = 4'($urandom) & 4'($urandom) & 4'($urandom);
      thi = 3'($urandom) & 3'($urandom);
      thy = 3'($urandom) & 3'($urandom);
      if ($urandom % 50 == 0) qsel = 2'($urandom);
      addr = alist[$urandom % 4];
      wr = ($urandom % 6) == 0;
      wdata = 8'($urandom);
      tick();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule